// File: doc/BRIEF.md
# Condition Code and Interrupt Level Register

This block holds the status word of a small 8-bit processor core. It keeps the negative, zero, two's-complement overflow, carry and half-carry flags produced by the ALU, a global interrupt enable bit, and a 2-bit current interrupt level. The ALU presents its result together with its carry out of the top bit, its carry out of bit 3, an overflow indication and the bit lost by a shift. An operation-class code says which of the flags that operation is allowed to change.

The block also decides whether a pending interrupt may be taken. A request carries a 2-bit level, where 0 is the most urgent and 3 the least. The request is accepted only when interrupts are enabled and its level number is strictly smaller than the held level. When a request is accepted, the held level takes the request's level. The enable bit is left for software to change. A direct write port loads the whole status word, for example when it is restored on return from an interrupt. That write overrides every other update in the same cycle.

Top module: `ccr_unit`

## Requirements
- R1: The status word `ccrOut` has this layout: bit 7 is the interrupt enable I, bits 6:5 are the interrupt level IL, bit 4 is the half-carry H, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. While `rstN` is low, and after it rises until the first update, the word reads 8'h60: I = 0, IL = 3, and every flag 0.
- R2: On a qualified operation (`opValid` = 1) of class logical (`opClass` = 1), shift (2) or arithmetic (3), N takes the result's top bit and Z is 1 exactly when the result is zero, in the cycle after the operation.
- R3: On an arithmetic operation (`opClass` = 3), V takes `ovfIn`, C takes `carryMsb` and H takes `carryNib`.
- R4: On a logical operation (`opClass` = 1), V, C and H keep their values.
- R5: On a shift operation (`opClass` = 2), C takes `shiftOut`, while V and H keep their values.
- R6: A move (`opClass` = 0), or any cycle with `opValid` = 0, leaves N, Z, V, C and H unchanged.
- R7: `irqAccept` is high in the same cycle exactly when `irqReq` = 1, I = 1 and `irqLevel` < IL. A level-3 request is therefore never accepted.
- R8: In the cycle after an accept with no direct write, IL equals the accepted `irqLevel` and I is unchanged.
- R9: When `wrEn` = 1, the next value of `ccrOut` is `wrData`, whatever operation or accept occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | ALU operation completes this cycle |
| opClass | input | 2 | 0 move, 1 logical, 2 shift, 3 arithmetic |
| aluResult | input | DATA_W | ALU result |
| carryMsb | input | 1 | Carry or borrow out of the top result bit |
| carryNib | input | 1 | Carry or borrow between bits 3 and 4 |
| ovfIn | input | 1 | Two's-complement overflow |
| shiftOut | input | 1 | Bit shifted out by a shift |
| wrEn | input | 1 | Direct write of the status word |
| wrData | input | 8 | Value for the direct write |
| irqReq | input | 1 | An interrupt request is pending |
| irqLevel | input | 2 | Level of the pending request |
| ccrOut | output | 8 | Current status word |
| irqAccept | output | 1 | The pending request is accepted |

## Verification
The hardest case to reach is an accept that lands in the same cycle as a flag update or a direct write. A random operation stream rarely produces it while interrupts are enabled and IL sits above the request level. The bench therefore starts with directed writes that set I = 1 with IL at 2 or 3. It then probes equal, lower and level-3 requests against that state. After that, random stimulus writes the word on about one cycle in eight, so that many runs sit in an enabled state and collide with accepts.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W  = 8;
  localparam int LVL_W  = 2;
  localparam int BIT_C  = 0;
  localparam int BIT_V  = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_N  = 3;
  localparam int BIT_H  = 4;
  localparam int IL_LO  = 5;
  localparam int IL_HI  = 6;
  localparam int BIT_I  = 7;
  localparam logic [CCR_W-1:0] CCR_RESET = 8'h60;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_LOGIC = 2'd1,
    OP_SHIFT = 2'd2,
    OP_ARITH = 2'd3
  } opClass_e;

  typedef struct packed {
    logic updNZ;
    logic updV;
    logic updH;
    logic updC;
    logic cFromShift;
    logic loadIl;
    logic loadAll;
  } ccrStrobe_t;
endpackage

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic             opValid,
  input  logic [1:0]       opClass,
  input  logic             wrEn,
  input  logic             irqReq,
  input  logic [LVL_W-1:0] irqLevel,
  input  logic             curEnable,
  input  logic [LVL_W-1:0] curLevel,
  output ccrStrobe_t       strobe,
  output logic             irqAccept
);
  opClass_e cls;
  logic     levelWins;

  assign cls       = opClass_e'(opClass);
  assign levelWins = (irqLevel < curLevel);
  assign irqAccept = irqReq & curEnable & levelWins;

  always_comb begin
    strobe = '0;
    if (wrEn) begin
      strobe.loadAll = 1'b1;
    end else begin
      strobe.loadIl = irqAccept;
      if (opValid) begin
        unique case (cls)
          OP_LOGIC: strobe.updNZ = 1'b1;
          OP_SHIFT: begin
            strobe.updNZ      = 1'b1;
            strobe.updC       = 1'b1;
            strobe.cFromShift = 1'b1;
          end
          OP_ARITH: begin
            strobe.updNZ = 1'b1;
            strobe.updV  = 1'b1;
            strobe.updH  = 1'b1;
            strobe.updC  = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccrStrobe_t        strobe,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              carryMsb,
  input  logic              carryNib,
  input  logic              ovfIn,
  input  logic              shiftOut,
  input  logic [CCR_W-1:0]  wrData,
  input  logic [LVL_W-1:0]  irqLevel,
  output logic [CCR_W-1:0]  ccr
);
  logic             flagN, flagZ, flagV, flagC, flagH, flagI;
  logic [LVL_W-1:0] level;
  logic             nextN, nextZ, nextC;

  assign nextN = aluResult[DATA_W-1];
  assign nextZ = ~|aluResult;
  assign nextC = strobe.cFromShift ? shiftOut : carryMsb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagN <= CCR_RESET[BIT_N];
      flagZ <= CCR_RESET[BIT_Z];
      flagV <= CCR_RESET[BIT_V];
      flagC <= CCR_RESET[BIT_C];
      flagH <= CCR_RESET[BIT_H];
      flagI <= CCR_RESET[BIT_I];
      level <= CCR_RESET[IL_HI:IL_LO];
    end else if (strobe.loadAll) begin
      flagN <= wrData[BIT_N];
      flagZ <= wrData[BIT_Z];
      flagV <= wrData[BIT_V];
      flagC <= wrData[BIT_C];
      flagH <= wrData[BIT_H];
      flagI <= wrData[BIT_I];
      level <= wrData[IL_HI:IL_LO];
    end else begin
      if (strobe.updNZ) begin
        flagN <= nextN;
        flagZ <= nextZ;
      end
      if (strobe.updV)   flagV <= ovfIn;
      if (strobe.updH)   flagH <= carryNib;
      if (strobe.updC)   flagC <= nextC;
      if (strobe.loadIl) level <= irqLevel;
    end
  end

  always_comb begin
    ccr              = '0;
    ccr[BIT_I]       = flagI;
    ccr[IL_HI:IL_LO] = level;
    ccr[BIT_H]       = flagH;
    ccr[BIT_N]       = flagN;
    ccr[BIT_Z]       = flagZ;
    ccr[BIT_V]       = flagV;
    ccr[BIT_C]       = flagC;
  end
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              carryMsb,
  input  logic              carryNib,
  input  logic              ovfIn,
  input  logic              shiftOut,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  input  logic              irqReq,
  input  logic [1:0]        irqLevel,
  output logic [7:0]        ccrOut,
  output logic              irqAccept
);
  ccrStrobe_t strobe;

  ccr_ctrl u_ctrl (
    .opValid   (opValid),
    .opClass   (opClass),
    .wrEn      (wrEn),
    .irqReq    (irqReq),
    .irqLevel  (irqLevel),
    .curEnable (ccrOut[BIT_I]),
    .curLevel  (ccrOut[IL_HI:IL_LO]),
    .strobe    (strobe),
    .irqAccept (irqAccept)
  );

  ccr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .aluResult (aluResult),
    .carryMsb  (carryMsb),
    .carryNib  (carryNib),
    .ovfIn     (ovfIn),
    .shiftOut  (shiftOut),
    .wrData    (wrData),
    .irqLevel  (irqLevel),
    .ccr       (ccrOut)
  );
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opClass,
  input logic [DATA_W-1:0] aluResult,
  input logic              wrEn,
  input logic [7:0]        wrData,
  input logic              irqReq,
  input logic [1:0]        irqLevel,
  input logic [7:0]        ccrOut,
  input logic              irqAccept
);
  AST_RESET_WORD: assert property (@(posedge clk) !rstN |=> (!rstN || ccrOut == 8'h60) || $past(rstN)); // R1
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass != 2'd0 && !wrEn) |=> ccrOut[2] == ($past(aluResult) == '0)); // R2
  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd1 && !wrEn) |=> ccrOut[4] == $past(ccrOut[4]) && ccrOut[1:0] == $past(ccrOut[1:0])); // R4
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    ((!opValid || opClass == 2'd0) && !wrEn) |=> ccrOut[4:0] == $past(ccrOut[4:0])); // R6
  AST_ACCEPT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |-> irqReq && ccrOut[7]); // R7
  AST_NO_LEVEL3: assert property (@(posedge clk) disable iff (!rstN)
    irqLevel == 2'd3 |-> !irqAccept); // R7
  AST_IL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (irqAccept && !wrEn) |=> ccrOut[6:5] == $past(irqLevel) && ccrOut[7] == $past(ccrOut[7])); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> ccrOut == $past(wrData)); // R9
endmodule

bind ccr_unit ccr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opClass   (opClass),
  .aluResult (aluResult),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .irqReq    (irqReq),
  .irqLevel  (irqLevel),
  .ccrOut    (ccrOut),
  .irqAccept (irqAccept)
);

// File: tb/ccr_unit_bench.sv
`timescale 1ns/1ps
module ccr_unit_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       opValid;
  logic [1:0] opClass;
  logic [7:0] aluResult;
  logic       carryMsb, carryNib, ovfIn, shiftOut;
  logic       wrEn;
  logic [7:0] wrData;
  logic       irqReq;
  logic [1:0] irqLevel;
  logic [7:0] ccrOut;
  logic       irqAccept;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] model;

  always #2 clk = ~clk;

  ccr_unit u_ccr_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .aluResult(aluResult), .carryMsb(carryMsb), .carryNib(carryNib),
    .ovfIn(ovfIn), .shiftOut(shiftOut), .wrEn(wrEn), .wrData(wrData),
    .irqReq(irqReq), .irqLevel(irqLevel), .ccrOut(ccrOut), .irqAccept(irqAccept)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
      finishRun();
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expAccept(logic [7:0] cur, logic rq, logic [1:0] lvl);
    return rq && cur[7] && (lvl < cur[6:5]);
  endfunction

  function automatic logic [7:0] expNext(logic [7:0] cur);
    logic [7:0] n;
    n = cur;
    if (wrEn) return wrData;
    if (opValid && opClass != 2'd0) begin
      n[3] = aluResult[7];
      n[2] = (aluResult == 8'h00);
      if (opClass == 2'd2) n[0] = shiftOut;
      if (opClass == 2'd3) begin
        n[1] = ovfIn; n[0] = carryMsb; n[4] = carryNib;
      end
    end
    if (expAccept(cur, irqReq, irqLevel)) n[6:5] = irqLevel;
    return n;
  endfunction

  // Drive inputs after a falling edge, check accept, clock, then check word.
  task automatic step(logic v, logic [1:0] cls, logic [7:0] res, logic c7, logic c3,
                      logic ov, logic so, logic we, logic [7:0] wd, logic rq, logic [1:0] lvl);
    logic [7:0] nxt;
    string t;
    opValid = v; opClass = cls; aluResult = res; carryMsb = c7; carryNib = c3;
    ovfIn = ov; shiftOut = so; wrEn = we; wrData = wd; irqReq = rq; irqLevel = lvl;
    #1;
    check("R7 accept", {7'd0, irqAccept}, {7'd0, expAccept(model, rq, lvl)});
    nxt = expNext(model);
    @(posedge clk);
    @(negedge clk);
    if (we) check("R9 write", ccrOut, nxt);
    else begin
      check("R2 NZ", {6'd0, ccrOut[3:2]}, {6'd0, nxt[3:2]});
      if (!v || cls == 2'd0) t = "R6 VCH";
      else if (cls == 2'd1) t = "R4 VCH";
      else if (cls == 2'd2) t = "R5 VCH";
      else t = "R3 VCH";
      check(t, {5'd0, ccrOut[4], ccrOut[1:0]}, {5'd0, nxt[4], nxt[1:0]});
      check("R8 IL and I", {5'd0, ccrOut[7:5]}, {5'd0, nxt[7:5]});
    end
    model = ccrOut;
  endtask

  initial begin
    void'($urandom(32'd5150));
    rstN = 1'b0; opValid = 0; opClass = 0; aluResult = 0; carryMsb = 0; carryNib = 0;
    ovfIn = 0; shiftOut = 0; wrEn = 0; wrData = 0; irqReq = 1; irqLevel = 0;
    repeat (3) @(negedge clk);
    check("R1 reset word", ccrOut, 8'h60);
    check("R1 no accept in reset", {7'd0, irqAccept}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", ccrOut, 8'h60);
    model = 8'h60;

    // R9 enable, IL=2
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hC0, 0, 0);
    // R7 equal level refused, level 3 refused, lower accepted (R8)
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3);
    step(1, 2'd3, 8'h00, 1, 1, 1, 0, 0, 0, 1, 2'd1);   // R3 zero result with carries plus accept
    // R5 shift loads C from shiftOut
    step(1, 2'd2, 8'h80, 0, 1, 1, 1, 0, 0, 0, 0);
    // R4 logical keeps V, C, H
    step(1, 2'd1, 8'h01, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 move and idle keep flags
    step(1, 2'd0, 8'h00, 1, 1, 1, 1, 0, 0, 0, 0);
    step(0, 2'd3, 8'h00, 1, 1, 1, 1, 0, 0, 0, 0);
    // R9 write beats an arithmetic op and an accept
    step(1, 2'd3, 8'hFF, 1, 1, 1, 1, 1, 8'h65, 1, 2'd0);
    // R7 disabled: no accept
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0);

    for (int i = 0; i < 3000; i++) begin
      logic we;
      we = ($urandom % 8) == 0;
      step($urandom % 4 != 0, 2'($urandom), 8'($urandom % 3 == 0 ? 0 : $urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           we, 8'($urandom), 1'($urandom), 2'($urandom));
    end
    finishRun();
  end
endmodule